// File: doc/BRIEF.md
# Early-Reject Nonce Search Controller

This controller runs a proof-of-work search over a data block where only a 32-bit nonce changes between candidates. It issues groups of consecutive nonces to a set of parallel hash lanes. Each request carries the group base, and lane `k` of the group hashes `base + k`. The hash engines live outside the block and return one 256-bit result per lane. Results come back in issue order, and each is tagged with its lane index.

Each result is screened one bit per cycle, following a programmable order table, so the bit that is cheapest to compute can be examined first. The first examined bit that is one drops the candidate, and its remaining bits are never examined. A candidate whose first N table entries all point at zero bits is reported as found. The search then stops. If every nonce up to 0xFFFFFFFF has been screened and none succeeded, the block raises exhausted instead. A counter of rejected candidates is available for statistics.

Top module: `nonce_search`

## Requirements
- R1: After reset, req_valid_o, found_o and exhausted_o are 0, rej_cnt_o is 0 and rsp_ready_o is 1.
- R2: A start pulse loads start_nonce_i with its low LANE_W bits cleared as the first group base. Each later request carries the previous base plus LANES, so req_nonce_o always has its low LANE_W bits at zero.
- R3: At most MAX_OUT groups are in flight. While MAX_OUT groups await responses, req_valid_o stays 0. It returns once the response tagged LANES-1 of the oldest group is accepted.
- R4: Order table entry j (written through ord_we_i/ord_addr_i/ord_idx_i) names a result bit, with bit 0 being the LSB of rsp_hash_i. Entries are examined from entry 0 upward, one per cycle. Result bits that no examined entry names have no effect.
- R5: A candidate whose first one bit sits at entry position p is rejected after p+1 busy cycles. rsp_ready_o is low for exactly those cycles, and no later entries are examined.
- R6: If entries 0 to N-1 all name zero bits (N = zero_cnt_i captured at start, 1 to 32), found_o rises after N busy cycles. found_nonce_o then equals the group base plus the lane tag.
- R7: Within a group, lanes are screened in tag order and the first success is reported, which is the lowest nonce. Responses after a success are accepted at once and discarded, and found_nonce_o does not change.
- R8: Once found_o or exhausted_o is set, no further requests are issued until the next start.
- R9: The group containing 0xFFFFFFFF is the last one issued. When all of its responses and all earlier ones have been rejected, exhausted_o rises and found_o stays 0.
- R10: rej_cnt_o counts rejected candidates and reads 0 in the cycle after a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start or restart a search |
| start_nonce_i | input | 32 | First nonce of the search |
| zero_cnt_i | input | 6 | Number of order entries that must be zero (1 to 32) |
| ord_we_i | input | 1 | Order table write enable |
| ord_addr_i | input | 5 | Order table entry |
| ord_idx_i | input | 8 | Result bit index stored in the entry |
| req_valid_o | output | 1 | Group request valid |
| req_ready_i | input | 1 | Lanes accept the group |
| req_nonce_o | output | 32 | Group base nonce |
| rsp_valid_i | input | 1 | Lane result valid |
| rsp_ready_o | output | 1 | Controller accepts a result |
| rsp_lane_i | input | 2 | Lane tag of the result |
| rsp_hash_i | input | 256 | Hash result of that lane |
| found_o | output | 1 | A winning nonce was found |
| found_nonce_o | output | 32 | The winning nonce |
| exhausted_o | output | 1 | Nonce space exhausted without a find |
| rej_cnt_o | output | 32 | Rejected candidate count |

## Verification
The bench targets the screening cost directly. It measures how long rsp_ready_o stays low for a one bit placed at entry 0, at a middle entry, at entry N-1, just past N, and at entry 31 with N=32. A scanner that examined past the first one bit, or that ignored N, would show the wrong busy length or a false find. Response hashes have every bit set except those the table names, so a wrong bit index or a wrong table order shows up as a premature reject. Further directed runs cover the following. A group where two lanes succeed must report the lower nonce. A stall must hold at MAX_OUT in-flight groups and release on the last lane. A search started near 0xFFFFFFFF must wrap into exhausted and not issue a group at 0.

// File: rtl/ns_pkg.sv
package ns_pkg;
  localparam int NONCE_W = 32;
  typedef logic [NONCE_W-1:0] nonce_t;
endpackage

// File: rtl/ns_issue.sv
module ns_issue
  import ns_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = $clog2(LANES)
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  nonce_t start_nonce_i,
  input  logic   run_i,
  input  logic   full_i,
  output logic   req_valid_o,
  input  logic   req_ready_i,
  output nonce_t req_nonce_o,
  output logic   done_o
);
  nonce_t base_q;
  logic   done_q;
  logic   carry;
  nonce_t base_nx;

  assign {carry, base_nx} = {1'b0, base_q} + (NONCE_W+1)'(LANES);
  assign req_valid_o      = run_i & ~done_q & ~full_i;
  assign req_nonce_o      = base_q;
  assign done_o           = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      done_q <= 1'b0;
    end else if (start_i) begin
      base_q <= {start_nonce_i[NONCE_W-1:LANE_W], {LANE_W{1'b0}}};
      done_q <= 1'b0;
    end else if (req_valid_o && req_ready_i) begin
      base_q <= base_nx;
      done_q <= carry;
    end
  end

  // R2
  base_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> req_nonce_o[LANE_W-1:0] == '0);
endmodule

// File: rtl/ns_track.sv
module ns_track
  import ns_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int MAX_OUT = 2,
  parameter int LANE_W  = $clog2(LANES),
  parameter int OUT_W   = $clog2(MAX_OUT+1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  nonce_t            start_nonce_i,
  input  logic              req_fire_i,
  input  logic              rsp_fire_i,
  input  logic [LANE_W-1:0] rsp_lane_i,
  output logic              full_o,
  output logic              empty_o,
  output nonce_t            rsp_nonce_o
);
  logic [OUT_W-1:0] out_cnt_q;
  nonce_t           rsp_base_q;
  logic             last_lane;

  assign last_lane   = rsp_fire_i && (rsp_lane_i == LANE_W'(LANES-1));
  assign full_o      = (out_cnt_q == OUT_W'(MAX_OUT));
  assign empty_o     = (out_cnt_q == '0);
  assign rsp_nonce_o = {rsp_base_q[NONCE_W-1:LANE_W], rsp_lane_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_cnt_q  <= '0;
      rsp_base_q <= '0;
    end else if (start_i) begin
      out_cnt_q  <= '0;
      rsp_base_q <= {start_nonce_i[NONCE_W-1:LANE_W], {LANE_W{1'b0}}};
    end else begin
      case ({req_fire_i, last_lane})
        2'b10:   out_cnt_q <= out_cnt_q + 1'b1;
        2'b01:   out_cnt_q <= out_cnt_q - 1'b1;
        default: out_cnt_q <= out_cnt_q;
      endcase
      if (last_lane) rsp_base_q <= rsp_base_q + NONCE_W'(LANES);
    end
  end

  // R3
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_cnt_q <= OUT_W'(MAX_OUT));
endmodule

// File: rtl/ns_scan.sv
module ns_scan
  import ns_pkg::*;
#(
  parameter int HASH_W    = 256,
  parameter int ORD_DEPTH = 32,
  parameter int IDX_W     = $clog2(HASH_W),
  parameter int ADDR_W    = $clog2(ORD_DEPTH),
  parameter int CNT_W     = $clog2(ORD_DEPTH)+1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic [CNT_W-1:0]  zero_cnt_i,
  input  logic              ord_we_i,
  input  logic [ADDR_W-1:0] ord_addr_i,
  input  logic [IDX_W-1:0]  ord_idx_i,
  input  logic              load_i,
  input  logic [HASH_W-1:0] hash_i,
  input  nonce_t            nonce_i,
  output logic              idle_o,
  output logic              hit_o,
  output logic              rej_o,
  output nonce_t            nonce_o
);
  logic [IDX_W-1:0]  order_q [ORD_DEPTH];
  logic              busy_q;
  logic [ADDR_W-1:0] step_q;
  logic [CNT_W-1:0]  zc_q;
  logic [HASH_W-1:0] hash_q;
  nonce_t            nonce_q;
  logic              cur_bit;
  logic              last_step;

  for (genvar j = 0; j < ORD_DEPTH; j++) begin : g_ord
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      order_q[j] <= '0;
      else if (ord_we_i && ord_addr_i == ADDR_W'(j))    order_q[j] <= ord_idx_i;
    end
  end

  assign cur_bit   = hash_q[order_q[step_q]];
  assign last_step = (CNT_W'(step_q) + 1'b1) >= zc_q;
  assign idle_o    = ~busy_q;
  assign rej_o     = busy_q & cur_bit;
  assign hit_o     = busy_q & ~cur_bit & last_step;
  assign nonce_o   = nonce_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      step_q  <= '0;
      zc_q    <= '0;
      hash_q  <= '0;
      nonce_q <= '0;
    end else if (flush_i) begin
      busy_q <= 1'b0;
      step_q <= '0;
      zc_q   <= zero_cnt_i;
    end else if (load_i) begin
      busy_q  <= 1'b1;
      step_q  <= '0;
      hash_q  <= hash_i;
      nonce_q <= nonce_i;
    end else if (busy_q) begin
      if (rej_o || hit_o) busy_q <= 1'b0;
      else                step_q <= step_q + 1'b1;
    end
  end

  // R5
  outcome_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({hit_o, rej_o, load_i}));
  // R4
  step_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && zc_q != '0) |-> CNT_W'(step_q) < zc_q);
endmodule

// File: rtl/nonce_search.sv
module nonce_search
  import ns_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int MAX_OUT   = 2,
  parameter int HASH_W    = 256,
  parameter int ORD_DEPTH = 32,
  parameter int LANE_W    = $clog2(LANES),
  parameter int IDX_W     = $clog2(HASH_W),
  parameter int ADDR_W    = $clog2(ORD_DEPTH),
  parameter int CNT_W     = $clog2(ORD_DEPTH)+1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [31:0]       start_nonce_i,
  input  logic [CNT_W-1:0]  zero_cnt_i,
  input  logic              ord_we_i,
  input  logic [ADDR_W-1:0] ord_addr_i,
  input  logic [IDX_W-1:0]  ord_idx_i,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [31:0]       req_nonce_o,
  input  logic              rsp_valid_i,
  output logic              rsp_ready_o,
  input  logic [LANE_W-1:0] rsp_lane_i,
  input  logic [HASH_W-1:0] rsp_hash_i,
  output logic              found_o,
  output logic [31:0]       found_nonce_o,
  output logic              exhausted_o,
  output logic [31:0]       rej_cnt_o
);
  logic   run_q, found_q, exh_q;
  nonce_t found_nonce_q;
  logic [31:0] rej_cnt_q;
  logic   full, empty, issue_done;
  logic   req_fire, rsp_fire, load;
  logic   scan_idle, scan_hit, scan_rej;
  nonce_t rsp_nonce, hit_nonce;
  logic   exhaust;

  assign req_fire    = req_valid_o & req_ready_i;
  assign rsp_ready_o = ~run_q | scan_idle;
  assign rsp_fire    = rsp_valid_i & rsp_ready_o & run_q;
  assign load        = rsp_fire;
  assign exhaust     = run_q & issue_done & empty & scan_idle;

  ns_issue #(.LANES(LANES), .LANE_W(LANE_W)) u_issue (
    .clk_i, .rst_ni, .start_i, .start_nonce_i,
    .run_i(run_q), .full_i(full),
    .req_valid_o, .req_ready_i, .req_nonce_o,
    .done_o(issue_done)
  );

  ns_track #(.LANES(LANES), .MAX_OUT(MAX_OUT), .LANE_W(LANE_W)) u_track (
    .clk_i, .rst_ni, .start_i, .start_nonce_i,
    .req_fire_i(req_fire), .rsp_fire_i(rsp_fire), .rsp_lane_i,
    .full_o(full), .empty_o(empty), .rsp_nonce_o(rsp_nonce)
  );

  ns_scan #(.HASH_W(HASH_W), .ORD_DEPTH(ORD_DEPTH), .IDX_W(IDX_W),
            .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_scan (
    .clk_i, .rst_ni, .flush_i(start_i), .zero_cnt_i,
    .ord_we_i, .ord_addr_i, .ord_idx_i,
    .load_i(load), .hash_i(rsp_hash_i), .nonce_i(rsp_nonce),
    .idle_o(scan_idle), .hit_o(scan_hit), .rej_o(scan_rej), .nonce_o(hit_nonce)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q         <= 1'b0;
      found_q       <= 1'b0;
      exh_q         <= 1'b0;
      found_nonce_q <= '0;
      rej_cnt_q     <= '0;
    end else if (start_i) begin
      run_q     <= 1'b1;
      found_q   <= 1'b0;
      exh_q     <= 1'b0;
      rej_cnt_q <= '0;
    end else begin
      if (scan_rej) rej_cnt_q <= rej_cnt_q + 1'b1;
      if (scan_hit && run_q) begin
        run_q         <= 1'b0;
        found_q       <= 1'b1;
        found_nonce_q <= hit_nonce;
      end else if (exhaust) begin
        run_q <= 1'b0;
        exh_q <= 1'b1;
      end
    end
  end

  assign found_o       = found_q;
  assign found_nonce_o = found_nonce_q;
  assign exhausted_o   = exh_q;
  assign rej_cnt_o     = rej_cnt_q;

  // R6
  found_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (found_o && !start_i) |=> found_o && $stable(found_nonce_o));
  // R8
  stop_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (found_o || exhausted_o) |-> !req_valid_o);
  // R9
  end_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(found_o && exhausted_o));
  // R10
  rej_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> rej_cnt_o == '0);
endmodule

// File: tb/nonce_search_bench.sv
module nonce_search_bench;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [31:0]  start_nonce_i = '0;
  logic [5:0]   zero_cnt_i = 6'd5;
  logic         ord_we_i = 1'b0;
  logic [4:0]   ord_addr_i = '0;
  logic [7:0]   ord_idx_i = '0;
  logic         req_valid_o;
  logic         req_ready_i = 1'b0;
  logic [31:0]  req_nonce_o;
  logic         rsp_valid_i = 1'b0;
  logic         rsp_ready_o;
  logic [1:0]   rsp_lane_i = '0;
  logic [255:0] rsp_hash_i = '0;
  logic         found_o;
  logic [31:0]  found_nonce_o;
  logic         exhausted_o;
  logic [31:0]  rej_cnt_o;

  int errors = 0;
  int checks = 0;

  always #2.5 clk_i = ~clk_i;

  nonce_search u_nonce_search (.*);

  // start(32) lane(2) one_pos(6, 63 = none) zc(6) busy(6) found(1)
  localparam logic [52:0] VEC [8] = '{
    {32'h0000_1000, 2'd0, 6'd0,  6'd5,  6'd1,  1'b0},
    {32'h0000_1003, 2'd3, 6'd2,  6'd5,  6'd3,  1'b0},
    {32'h1234_5678, 2'd1, 6'd4,  6'd5,  6'd5,  1'b0},
    {32'h0000_0040, 2'd2, 6'd63, 6'd5,  6'd5,  1'b1},
    {32'hABCD_EF00, 2'd3, 6'd5,  6'd5,  6'd5,  1'b1},
    {32'h0000_0007, 2'd1, 6'd63, 6'd1,  6'd1,  1'b1},
    {32'h0000_0080, 2'd0, 6'd63, 6'd32, 6'd32, 1'b1},
    {32'h0000_0080, 2'd0, 6'd31, 6'd32, 6'd32, 1'b0}
  };

  function automatic logic [7:0] idx(int k);
    return 8'((224 + 31*k) % 256);
  endfunction

  function automatic logic [255:0] mk_hash(int p);
    logic [255:0] h = '1;
    for (int k = 0; k < 32; k++) h[idx(k)] = 1'b0;
    if (p < 32) h[idx(p)] = 1'b1;
    return h;
  endfunction

  task automatic check(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_start(logic [31:0] n, logic [5:0] zc);
    @(negedge clk_i);
    start_i = 1'b1; start_nonce_i = n; zero_cnt_i = zc;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic take_req(output logic [31:0] n);
    while (!req_valid_o) @(negedge clk_i);
    n = req_nonce_o;
    req_ready_i = 1'b1;
    @(negedge clk_i);
    req_ready_i = 1'b0;
  endtask

  task automatic send_rsp(logic [1:0] lane, int p, output int busy);
    while (!rsp_ready_o) @(negedge clk_i);
    rsp_valid_i = 1'b1; rsp_lane_i = lane; rsp_hash_i = mk_hash(p);
    @(negedge clk_i);
    rsp_valid_i = 1'b0;
    busy = 0;
    while (!rsp_ready_o) begin busy++; @(negedge clk_i); end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] n;
    int busy;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1
    check(req_valid_o == 0, "R1 req_valid", req_valid_o, 0);
    check(found_o == 0, "R1 found", found_o, 0);
    check(exhausted_o == 0, "R1 exhausted", exhausted_o, 0);
    check(rej_cnt_o == 0, "R1 rej_cnt", rej_cnt_o, 0);
    check(rsp_ready_o == 1, "R1 rsp_ready", rsp_ready_o, 1);

    for (int k = 0; k < 32; k++) begin
      ord_we_i = 1'b1; ord_addr_i = 5'(k); ord_idx_i = idx(k);
      @(negedge clk_i);
    end
    ord_we_i = 1'b0;

    // R4 R5 R6 vector walk
    for (int v = 0; v < 8; v++) begin
      logic [31:0] sn;
      logic [1:0]  ln;
      int pos, zc, eb;
      bit ef;
      sn = VEC[v][52:21]; ln = VEC[v][20:19]; pos = int'(VEC[v][18:13]);
      zc = int'(VEC[v][12:7]); eb = int'(VEC[v][6:1]); ef = VEC[v][0];
      do_start(sn, 6'(zc));
      take_req(n);
      check(n == {sn[31:2], 2'b00}, "R2 first base", n, {sn[31:2], 2'b00});
      send_rsp(ln, pos, busy);
      check(busy == eb, "R5 busy cycles", busy, eb);
      @(negedge clk_i);
      check(found_o == ef, "R6 found flag", found_o, ef);
      if (ef) begin
        check(found_nonce_o == {sn[31:2], ln}, "R6 found nonce", found_nonce_o, {sn[31:2], ln});
        check(req_valid_o == 0, "R8 no issue after found", req_valid_o, 0);
      end else begin
        check(rej_cnt_o == 1, "R10 rej count", rej_cnt_o, 1);
      end
    end

    // R3 stall and release, R2 stride
    do_start(32'h0, 6'd5);
    take_req(n);
    take_req(n);
    check(n == 32'h4, "R2 second base", n, 32'h4);
    @(negedge clk_i);
    check(req_valid_o == 0, "R3 stall at limit", req_valid_o, 0);
    for (int l = 0; l < 3; l++) send_rsp(2'(l), 0, busy);
    check(req_valid_o == 0, "R3 still stalled before last lane", req_valid_o, 0);
    send_rsp(2'd3, 0, busy);
    check(req_valid_o == 1, "R3 released", req_valid_o, 1);
    check(req_nonce_o == 32'h8, "R2 third base", req_nonce_o, 32'h8);

    // R7 lowest nonce wins
    do_start(32'h100, 6'd5);
    take_req(n);
    send_rsp(2'd0, 0, busy);
    send_rsp(2'd1, 63, busy);
    send_rsp(2'd2, 63, busy);
    check(busy == 0, "R7 later lane discarded", busy, 0);
    @(negedge clk_i);
    check(found_nonce_o == 32'h101, "R7 lowest nonce", found_nonce_o, 32'h101);
    check(rej_cnt_o == 1, "R7 rej count", rej_cnt_o, 1);

    // R9 exhaustion near wrap
    do_start(32'hFFFF_FFF9, 6'd5);
    take_req(n);
    check(n == 32'hFFFF_FFF8, "R9 base", n, 32'hFFFF_FFF8);
    take_req(n);
    check(n == 32'hFFFF_FFFC, "R9 last base", n, 32'hFFFF_FFFC);
    for (int l = 0; l < 4; l++) send_rsp(2'(l), 0, busy);
    check(req_valid_o == 0, "R9 no group after wrap", req_valid_o, 0);
    check(exhausted_o == 0, "R9 not yet exhausted", exhausted_o, 0);
    for (int l = 0; l < 4; l++) send_rsp(2'(l), 1, busy);
    @(negedge clk_i);
    check(exhausted_o == 1, "R9 exhausted", exhausted_o, 1);
    check(found_o == 0, "R9 no find", found_o, 0);
    check(rej_cnt_o == 8, "R10 rej total", rej_cnt_o, 8);
    do_start(32'h0, 6'd5);
    check(rej_cnt_o == 0, "R10 clear on start", rej_cnt_o, 0);
    check(exhausted_o == 0, "R9 exhausted cleared", exhausted_o, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule